// File: doc/BRIEF.md
# Framed PCM Serial Voice Port

This block is the digital serial side of a single-channel 8 kHz voice codec. Its transmit half takes 8-bit companded samples from the encoder through a valid/ready stream, keeps one of them in a holding register, and shifts that byte out MSB first. The output pin is open-drain: it pulls low for a 0 bit and releases the line otherwise. Each byte goes out in an 8-bit slot, and the slot opens when a rising edge of the transmit frame sync is seen. The receive half samples the serial input once per bit period. A receive frame sync that is independent of the transmit one marks the MSB. After eight bits the assembled byte goes out on a valid/ready stream towards the decoder.

The serial pins (bit clock, both frame syncs, input data and the power enable) are asynchronous to the system clock. They are resynchronised through one shared chain, so their phase relation to one another is kept. A transmit bit is launched on a rising bit-clock edge. A receive bit, and the receive sync, are taken on a falling bit-clock edge. The transmit sync is taken on a rising edge. The block also derives an operating mode. It is normal while both the bit clock and the transmit sync keep toggling. It is power-saving when either of them has shown no edge for a parameterised number of system clocks. It is power-down while the power enable is low. In any mode other than normal the output slot is closed and the pin is released.

On the transmit stream, back-pressure comes from the holding register: `tx_ready` is low from the cycle after a byte is accepted until that byte is moved into the shifter at the next slot start. On the receive stream, `rx_valid` stays high until `rx_ready` is seen. A serial line cannot be stalled, so a byte completed while an older one is still waiting replaces the older one.

Top module: `pcm_voice_port`

## Requirements
- R1: During reset and afterwards, until edges have been seen on both the bit clock and the transmit sync, `mode` reads power-saving (2'd1), `pcm_out_slot` and `pcm_out_pull` are 0, `rx_valid` is 0 and `tx_ready` is 1, provided `power_on` is 1.
- R2: The first receive bit is the one sampled on the falling bit-clock edge at which `rx_sync` is first seen high. That bit becomes `rx_data[7]` and the seven bits that follow fill bits 6 down to 0. The byte appears with `rx_valid` a few system clocks after the eighth falling edge.
- R3: `rx_valid` holds until a cycle with `rx_ready` high. A byte completed while `rx_valid` is still set overwrites `rx_data`, and only the latest byte is delivered.
- R4: A byte accepted on the transmit stream goes out in the next slot. The slot opens on the first rising bit-clock edge at which `tx_sync` is seen high after being low. Bits go out MSB first, one per bit-clock period, and a 0 bit drives `pcm_out_pull` to 1.
- R5: `tx_ready` is 0 while the holding register is full. A byte accepted during an open slot does not disturb that slot and goes out in the following frame.
- R6: If the holding register is empty when a slot opens, the slot carries the idle code 8'hFF, so the slot flag is set but the pin is never pulled low.
- R7: `pcm_out_slot` is 1 for exactly eight bit-clock periods per frame. `pcm_out_pull` is 1 only inside the slot.
- R8: When the bit clock shows no edge for `BCLK_TIMEOUT` system clocks, `mode` becomes power-saving and any open slot closes at once, releasing the pin.
- R9: When the transmit sync shows no edge for `FSYNC_TIMEOUT` system clocks, `mode` becomes power-saving even though the bit clock is running.
- R10: While `power_on` is 0, `mode` is power-down (2'd2), overriding the other modes. The pin stays released and no received byte is delivered.
- R11: Once bit-clock and transmit-sync edges return, `mode` goes back to normal (2'd0), and transmit and receive traffic resume from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_on | input | 1 | 0 forces power-down, asynchronous |
| bclk | input | 1 | Serial bit clock, asynchronous |
| tx_sync | input | 1 | Transmit frame sync, phase-locked to bclk |
| rx_sync | input | 1 | Receive frame sync, phase-locked to bclk |
| pcm_in | input | 1 | Serial receive data |
| pcm_out_pull | output | 1 | 1 pulls the open-drain output line low |
| pcm_out_slot | output | 1 | 1 while the transmit slot is open |
| tx_valid | input | 1 | Transmit stream valid |
| tx_data | input | WORD_W | Transmit byte |
| tx_ready | output | 1 | Holding register can take a byte |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | WORD_W | Received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| mode | output | 2 | 0 normal, 1 power-saving, 2 power-down |

## Verification
The assertions assume that each sync is high for at least one bit-clock period and low for at least one. They also assume the serial pins change only near bit-clock edges, and that half a bit-clock period spans more system clocks than the resynchroniser delay. With those assumptions an open slot is a clean run of eight bits, and held-valid and full-holding behaviour follow from the stream rules alone. The stimulus moves the receive sync and data only on rising bit-clock edges and the transmit sync only on falling ones. It uses half periods of four system clocks or more, and it stops the bit clock or the sync only as whole-signal stalls much longer than a frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SAVE   = 2'd1,
    MODE_DOWN   = 2'd2
  } port_mode_e;

  localparam int PIN_COUNT = 5;

endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int             W       = 5,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  end

  assign pin_o = chain_q[STAGES-1];

endmodule

// File: rtl/pcm_edge_watch.sv
module pcm_edge_watch #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic stalled_o
);

  localparam int            CW  = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] TOP = CW'(TIMEOUT);

  logic          prev_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      idle_q <= TOP;
    end else begin
      prev_q <= level_i;
      if (level_i != prev_q) begin
        idle_q <= '0;
      end else if (idle_q != TOP) begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign stalled_o = (idle_q == TOP);

endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int             W         = 8,
  parameter logic [W-1:0]   IDLE_CODE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         bclk_lvl,
  input  logic         sync_lvl,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         slot_o,
  output logic         pull_o
);

  localparam int            CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             bclk_prev_q;
  logic             sync_prev_q;
  logic [W-1:0]     hold_q;
  logic             hold_full_q;
  logic [W-1:0]     shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  logic tick;
  logic frame_start;
  logic accept;

  assign tick        = bclk_lvl & ~bclk_prev_q;
  assign frame_start = tick & sync_lvl & ~sync_prev_q & ~flush;
  assign accept      = tx_valid & ~hold_full_q;
  assign tx_ready    = ~hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      sync_prev_q <= 1'b0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shift_q     <= IDLE_CODE;
      cnt_q       <= '0;
      active_q    <= 1'b0;
    end else begin
      bclk_prev_q <= bclk_lvl;
      if (tick) begin
        sync_prev_q <= sync_lvl;
      end

      if (flush) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (frame_start) begin
        shift_q  <= hold_full_q ? hold_q : IDLE_CODE;
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (tick && active_q) begin
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          shift_q <= {shift_q[W-2:0], 1'b1};
        end
      end

      if (frame_start) begin
        hold_full_q <= accept;
      end else if (accept) begin
        hold_full_q <= 1'b1;
      end
      if (accept) begin
        hold_q <= tx_data;
      end
    end
  end

  assign slot_o = active_q;
  assign pull_o = active_q & ~shift_q[W-1];

endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         bclk_lvl,
  input  logic         sync_lvl,
  input  logic         data_lvl,
  input  logic         rx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);

  localparam int               CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(W - 1);

  logic             bclk_prev_q;
  logic             sync_prev_q;
  logic [W-1:0]     shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [W-1:0]     data_q;
  logic             valid_q;

  logic tick;
  logic start;
  logic done;

  assign tick  = ~bclk_lvl & bclk_prev_q;
  assign start = tick & sync_lvl & ~sync_prev_q & ~flush;
  assign done  = tick & busy_q & (cnt_q == LAST) & ~flush & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      sync_prev_q <= 1'b0;
      shift_q     <= '0;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      data_q      <= '0;
      valid_q     <= 1'b0;
    end else begin
      bclk_prev_q <= bclk_lvl;
      if (tick) begin
        sync_prev_q <= sync_lvl;
      end

      if (flush) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start) begin
        shift_q <= {shift_q[W-2:0], data_lvl};
        cnt_q   <= CNT_W'(1);
        busy_q  <= 1'b1;
      end else if (tick && busy_q) begin
        shift_q <= {shift_q[W-2:0], data_lvl};
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      if (done) begin
        data_q  <= {shift_q[W-2:0], data_lvl};
        valid_q <= 1'b1;
      end else if (rx_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rx_valid = valid_q;
  assign rx_data  = data_q;

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int                  WORD_W        = 8,
  parameter int                  SYNC_STAGES   = 2,
  parameter int                  BCLK_TIMEOUT  = 64,
  parameter int                  FSYNC_TIMEOUT = 25000,
  parameter logic [WORD_W-1:0]   IDLE_CODE     = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_on,
  input  logic              bclk,
  input  logic              tx_sync,
  input  logic              rx_sync,
  input  logic              pcm_in,
  output logic              pcm_out_pull,
  output logic              pcm_out_slot,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic [1:0]        mode
);

  localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(5'b10000);

  logic [PIN_COUNT-1:0] pins_s;
  logic pwr_s, bclk_s, txs_s, rxs_s, din_s;
  logic bclk_stall, txs_stall;
  logic flush;
  port_mode_e mode_q, mode_d;

  pcm_pin_sync #(
    .W       (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({power_on, bclk, tx_sync, rx_sync, pcm_in}),
    .pin_o (pins_s)
  );

  assign {pwr_s, bclk_s, txs_s, rxs_s, din_s} = pins_s;

  pcm_edge_watch #(.TIMEOUT(BCLK_TIMEOUT)) u_bclk_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (bclk_s),
    .stalled_o (bclk_stall)
  );

  pcm_edge_watch #(.TIMEOUT(FSYNC_TIMEOUT)) u_sync_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (txs_s),
    .stalled_o (txs_stall)
  );

  always_comb begin
    if (!pwr_s) begin
      mode_d = MODE_DOWN;
    end else if (bclk_stall || txs_stall) begin
      mode_d = MODE_SAVE;
    end else begin
      mode_d = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SAVE;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign flush = (mode_q != MODE_NORMAL);
  assign mode  = mode_q;

  pcm_tx_slot #(
    .W         (WORD_W),
    .IDLE_CODE (IDLE_CODE)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .bclk_lvl (bclk_s),
    .sync_lvl (txs_s),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .slot_o   (pcm_out_slot),
    .pull_o   (pcm_out_pull)
  );

  pcm_rx_slot #(.W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .bclk_lvl (bclk_s),
    .sync_lvl (rxs_s),
    .data_lvl (din_s),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pcm_out_pull,
  input logic       pcm_out_slot,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [1:0] mode
);

  // R7: the line is only pulled inside the slot
  p_pull_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_out_slot |-> !pcm_out_pull);

  // R8: leaving normal mode closes the slot on the next cycle
  p_slot_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> !pcm_out_slot);

  // R3: a pending received byte is held until taken
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R5: an accepted byte fills the holding register
  p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R10: mode only takes its three defined codes
  p_mode_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (.*);

// File: tb/pcm_voice_port_tb.sv
module pcm_voice_port_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, power_on, bclk, tx_sync, rx_sync, pcm_drv, loop_mode;
  logic       tx_valid, rx_ready;
  logic [7:0] tx_data;
  logic       pcm_in, pull, slot, tx_ready, rx_valid;
  logic [7:0] rx_data;
  logic [1:0] mode;

  assign pcm_in = loop_mode ? ~pull : pcm_drv;

  pcm_voice_port #(
    .BCLK_TIMEOUT  (64),
    .FSYNC_TIMEOUT (2000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .power_on(power_on), .bclk(bclk),
    .tx_sync(tx_sync), .rx_sync(rx_sync), .pcm_in(pcm_in),
    .pcm_out_pull(pull), .pcm_out_slot(slot),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .mode(mode)
  );

  int total = 0;
  int bad   = 0;
  int rx_cnt = 0;
  logic [7:0] rx_got = 8'h00;

  always @(posedge clk) begin
    if (rx_valid && rx_ready) begin
      rx_cnt <= rx_cnt + 1;
      rx_got <= rx_data;
    end
  end

  int hp, push_at;
  bit xs_en, chk_rx;
  logic [7:0] push_byte, rx_byte, cur_exp, nxt_exp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pull(input logic [7:0] b, input int k);
    return ~b[7-k];
  endfunction

  task automatic wait_clk(input int n);
    logic will;
    repeat (n) begin
      will = tx_valid & tx_ready;
      @(negedge clk);
      if (will) tx_valid = 1'b0;
    end
  endtask

  task automatic run_frame(input int last_p, input bit chk);
    int c0;
    logic [7:0] rx_exp;
    c0 = rx_cnt;
    rx_exp = 8'h00;
    for (int p = 0; p <= last_p; p++) begin
      if (chk && p >= 1 && p <= 8) begin
        check(slot === 1'b1, "R7 slot open", int'(slot), 1);
        check(pull === exp_pull(cur_exp, p-1),
              (cur_exp == 8'hFF) ? "R6 idle bit" : "R4 data bit",
              int'(pull), int'(exp_pull(cur_exp, p-1)));
      end
      if (chk && (p == 0 || p == 12))
        check(slot === 1'b0 && pull === 1'b0, "R7 released", int'({slot, pull}), 0);
      if (p == 0) begin
        cur_exp = nxt_exp;
        nxt_exp = 8'hFF;
        c0 = rx_cnt;
        rx_exp = loop_mode ? cur_exp : rx_byte;
      end
      bclk = 1'b1;
      rx_sync = (p < 2);
      pcm_drv = (p < 8) ? rx_byte[7-p] : 1'($urandom % 2);
      wait_clk(hp);
      bclk = 1'b0;
      tx_sync = xs_en && (p == 15 || p == 0);
      if (p == push_at) begin
        tx_valid = 1'b1;
        tx_data  = push_byte;
        nxt_exp  = push_byte;
      end
      if (chk && push_at >= 0 && p == push_at + 1)
        check(tx_ready === 1'b0, "R5 ready low while full", int'(tx_ready), 0);
      wait_clk(hp);
      if (chk_rx && p == 12) begin
        check(rx_cnt == c0 + 1, "R2 one byte per frame", rx_cnt - c0, 1);
        check(rx_got == rx_exp, loop_mode ? "R11 loopback byte" : "R2 rx byte",
              int'(rx_got), int'(rx_exp));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'd4242));
    rst_n = 1'b0; power_on = 1'b1; bclk = 1'b0; tx_sync = 1'b0; rx_sync = 1'b0;
    pcm_drv = 1'b0; loop_mode = 1'b0; tx_valid = 1'b0; tx_data = 8'h00; rx_ready = 1'b1;
    hp = 4; push_at = -1; xs_en = 1'b1; chk_rx = 1'b0;
    push_byte = 8'h00; rx_byte = 8'h00; cur_exp = 8'hFF; nxt_exp = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    check(mode === 2'd1, "R1 mode after reset", int'(mode), 1);
    check(slot === 1'b0 && pull === 1'b0, "R1 line released", int'({slot, pull}), 0);
    check(rx_valid === 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    check(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);

    run_frame(15, 1'b0);
    run_frame(15, 1'b0);
    check(mode === 2'd0, "R11 normal once edges seen", int'(mode), 0);

    // random traffic at several clock ratios (R2, R4, R11 loopback)
    chk_rx = 1'b1;
    for (int r = 0; r < 3; r++) begin
      hp = (r == 0) ? 4 : (r == 1) ? 6 : 11;
      loop_mode = (r != 0);
      for (int f = 0; f < 4; f++) begin
        push_at = 10;
        push_byte = 8'($urandom);
        rx_byte = 8'($urandom);
        run_frame(15, 1'b1);
      end
    end

    // R5 / R6 directed: mid-slot load waits a frame, empty holding sends idle
    loop_mode = 1'b0; hp = 5;
    push_at = 10; push_byte = 8'h3C; rx_byte = 8'hA5; run_frame(15, 1'b1);
    push_at = 3;  push_byte = 8'h81; rx_byte = 8'h00; run_frame(15, 1'b1);
    check(cur_exp == 8'h3C, "R5 slot kept its byte", int'(cur_exp), 8'h3C);
    push_at = -1; rx_byte = 8'hFF; run_frame(15, 1'b1);
    check(cur_exp == 8'h81, "R5 deferred byte sent", int'(cur_exp), 8'h81);
    run_frame(15, 1'b1);

    // R3 hold and overwrite
    chk_rx = 1'b0; rx_ready = 1'b0;
    rx_byte = 8'h5A; run_frame(15, 1'b0);
    rx_byte = 8'hC3; run_frame(15, 1'b0);
    check(rx_valid === 1'b1, "R3 valid held", int'(rx_valid), 1);
    check(rx_data === 8'hC3, "R3 latest byte kept", int'(rx_data), 8'hC3);
    c = rx_cnt;
    rx_ready = 1'b1;
    wait_clk(3);
    check(rx_cnt == c + 1 && rx_got == 8'hC3, "R3 single delivery", int'(rx_got), 8'hC3);
    check(rx_valid === 1'b0, "R3 valid drops", int'(rx_valid), 0);

    // R8 bit clock stall mid-slot
    chk_rx = 1'b1; push_at = 10; push_byte = 8'h00; rx_byte = 8'h66;
    run_frame(15, 1'b1);
    push_at = -1; chk_rx = 1'b0;
    run_frame(3, 1'b0);
    check(slot === 1'b1, "R8 slot open before stall", int'(slot), 1);
    wait_clk(100);
    check(mode === 2'd1, "R8 saving on clock stall", int'(mode), 1);
    check(slot === 1'b0 && pull === 1'b0, "R8 line released", int'({slot, pull}), 0);
    nxt_exp = 8'hFF;
    run_frame(15, 1'b0);
    run_frame(15, 1'b0);
    check(mode === 2'd0, "R11 normal after clock restart", int'(mode), 0);
    chk_rx = 1'b1; loop_mode = 1'b1;
    push_at = 10; push_byte = 8'hE7; run_frame(15, 1'b1);
    push_at = -1; run_frame(15, 1'b1);

    // R9 transmit sync stall with running bit clock
    chk_rx = 1'b0; loop_mode = 1'b0; hp = 4; xs_en = 1'b0;
    for (int f = 0; f < 20; f++) run_frame(15, 1'b0);
    check(mode === 2'd1, "R9 saving on sync stall", int'(mode), 1);
    check(slot === 1'b0, "R9 no slot", int'(slot), 0);
    xs_en = 1'b1; nxt_exp = 8'hFF;
    run_frame(15, 1'b0);
    run_frame(15, 1'b0);
    check(mode === 2'd0, "R11 normal after sync restart", int'(mode), 0);

    // R10 power-down override
    power_on = 1'b0;
    wait_clk(6);
    check(mode === 2'd2, "R10 power-down mode", int'(mode), 2);
    c = rx_cnt;
    rx_byte = 8'h12;
    run_frame(4, 1'b0);
    check(slot === 1'b0 && pull === 1'b0, "R10 line released", int'({slot, pull}), 0);
    run_frame(15, 1'b0);
    check(rx_cnt == c, "R10 no rx delivery", rx_cnt - c, 0);
    power_on = 1'b1;
    nxt_exp = 8'hFF;
    run_frame(15, 1'b0);
    check(mode === 2'd0, "R11 normal after power-up", int'(mode), 0);
    chk_rx = 1'b1; rx_byte = 8'h9D;
    run_frame(15, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule